// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one general-purpose input before it reaches the pin status bit and the interrupt detector. The raw pin is first brought into the system clock domain by a two-flop synchroniser. A filter then decides when the cleaned output may follow the synchronised level. The filter runs on a slow real-time clock. That clock reaches the block as a one-cycle enable, `rtc_tick`, and only cycles that carry this enable advance the filter's timing.

The filter is set up through a single configuration write. The write loads four things: a 2-bit filter type, a 4-bit timeout count, a unit-select bit and a range bit. The range bit and the unit-select bit together choose how many ticks make up one timeout unit. The filter type can be one of four:

- pass the input straight through;
- reject short pulses of either polarity;
- let low pulses through and filter only high ones;
- let high pulses through and filter only low ones.

Every configuration write also produces a one-cycle `sts_block` pulse. The surrounding logic uses it to hold off status generation while the filter settings change.

Top module: `glitch_filter`

## Requirements
- R1: After synchronous reset, `pin_filt` is 0 and `sts_block` is 0.
- R2: With filter type 0 (off), `pin_filt` takes a new `pin_raw` level on the 3rd rising clock edge after the input changes: two synchroniser stages plus one output register. The stored count, unit and range fields are cleared to zero when type 0 is written.
- R3: With filter type 1 (reject both), `pin_filt` changes only after the synchronised input has held the opposite level for T ticks. T = count × unit. With a tick on every cycle, the output changes on rising edge 2+T after the input change.
- R4: The ticks per unit are set by the pair {range, unit}: 00 gives 2 ticks, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R5: A count of 0 with the filter enabled acts as a count of 1, so T equals one unit.
- R6: If the synchronised input returns to the output's level before T ticks have passed, the accumulated time is discarded. A pulse shorter than T never reaches `pin_filt`.
- R7: Filter type 2 (keep low pulses): a fall to 0 reaches `pin_filt` on edge 3 with no delay. A rise to 1 must be stable for T ticks, so a high pulse shorter than T is removed.
- R8: Filter type 3 (keep high pulses) mirrors type 2: a rise passes on edge 3, and a fall must be stable for T ticks.
- R9: Only cycles with `rtc_tick` high count toward T. While the tick stays low, a filtered transition is held off indefinitely.
- R10: A cycle with `cfg_we` high makes `sts_block` high for exactly the following cycle. The write also discards any accumulated filter time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_tick | input | 1 | One-cycle enable marking each real-time clock tick |
| pin_raw | input | 1 | Unsynchronised pin level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Filter type: 0 off, 1 reject both, 2 keep low pulses, 3 keep high pulses |
| cfg_count | input | 4 | Timeout count in units |
| cfg_unit | input | 1 | Unit select: the fine or coarse step within the chosen range |
| cfg_range | input | 1 | Range select: the small or large tick multiples |
| pin_filt | output | 1 | Filtered pin level |
| sts_block | output | 1 | One-cycle pulse after each configuration write |

## Verification
All latencies are counted from the first rising edge after the bench changes `pin_raw` on a falling edge.

- **Unfiltered transitions** are due on edge 3. This applies to type 0 and to the unfiltered direction of types 2 and 3.
- **Filtered transitions** are due on edge 2+T. T is computed in the bench from the count and the R4 unit table, with a tick on every cycle.
- **`sts_block`** is due one edge after the write.

The bench samples on falling edges. For each table row it counts the rising edges until `pin_filt` changes and compares that count exactly with the expected latency, so both an early and a late output are caught. Glitch, restart and tick-gating cases watch the output over a window longer than T and require it to stay unchanged.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    localparam int TMO_W = 4;

    typedef enum logic [1:0] {
        FLT_OFF       = 2'd0,
        FLT_BOTH      = 2'd1,
        FLT_KEEP_LOW  = 2'd2,
        FLT_KEEP_HIGH = 2'd3
    } flt_mode_e;

    typedef struct packed {
        flt_mode_e          mode;
        logic [TMO_W-1:0]   count;
        logic               unit_sel;
        logic               range_sel;
    } flt_cfg_t;

    // Decides whether a transition towards new_lvl has to wait out the timeout.
    function automatic logic needs_delay(flt_mode_e mode, logic new_lvl);
        case (mode)
            FLT_BOTH:      return 1'b1;
            FLT_KEEP_LOW:  return new_lvl;
            FLT_KEEP_HIGH: return ~new_lvl;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/dbf_cfg.sv
module dbf_cfg
    import dbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       mode_i,
    input  logic [TMO_W-1:0] count_i,
    input  logic             unit_i,
    input  logic             range_i,
    output flt_cfg_t         cfg_o,
    output logic             blank_o
);
    flt_cfg_t cfg_q;
    flt_cfg_t cfg_d;
    logic     blank_q;

    always_comb begin
        cfg_d.mode = flt_mode_e'(mode_i);
        if (cfg_d.mode == FLT_OFF) begin
            cfg_d.count     = '0;
            cfg_d.unit_sel  = 1'b0;
            cfg_d.range_sel = 1'b0;
        end else begin
            cfg_d.count     = count_i;
            cfg_d.unit_sel  = unit_i;
            cfg_d.range_sel = range_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            blank_q <= 1'b0;
        end else begin
            blank_q <= we;
            if (we) cfg_q <= cfg_d;
        end
    end

    assign cfg_o   = cfg_q;
    assign blank_o = blank_q;
endmodule

// File: rtl/dbf_timer.sv
module dbf_timer
    import dbf_pkg::*;
#(
    parameter int TICKS_FINE   = 2,
    parameter int TICKS_MID    = 8,
    parameter int TICKS_COARSE = 512,
    parameter int TICKS_MAX    = 2048,
    parameter int CNT_W        = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic             lvl,
    input  flt_cfg_t         cfg,
    output logic             out,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] target
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] unit_len;
    logic [CNT_W-1:0] eff_count;
    logic             out_q;

    always_comb begin
        case ({cfg.range_sel, cfg.unit_sel})
            2'b00:   unit_len = CNT_W'(TICKS_FINE);
            2'b01:   unit_len = CNT_W'(TICKS_MID);
            2'b10:   unit_len = CNT_W'(TICKS_COARSE);
            default: unit_len = CNT_W'(TICKS_MAX);
        endcase
        eff_count = (cfg.count == '0) ? CNT_W'(1) : CNT_W'(cfg.count);
        target    = eff_count * unit_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (lvl == out_q) begin
            cnt_q <= '0;
        end else if (!needs_delay(cfg.mode, lvl)) begin
            out_q <= lvl;
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == target - CNT_W'(1)) begin
                out_q <= lvl;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign out = out_q;
    assign cnt = cnt_q;
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
    import dbf_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int TICKS_FINE   = 2,
    parameter int TICKS_MID    = 8,
    parameter int TICKS_COARSE = 512,
    parameter int TICKS_MAX    = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rtc_tick,
    input  logic             pin_raw,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [TMO_W-1:0] cfg_count,
    input  logic             cfg_unit,
    input  logic             cfg_range,
    output logic             pin_filt,
    output logic             sts_block
);
    localparam int MAX_TICKS = ((1 << TMO_W) - 1) * TICKS_MAX;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic             sync_lvl;
    flt_cfg_t         cfg_q;
    logic [CNT_W-1:0] tmr_cnt;
    logic [CNT_W-1:0] tmr_target;

    dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pin_raw),
        .d_out (sync_lvl)
    );

    dbf_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .mode_i  (cfg_mode),
        .count_i (cfg_count),
        .unit_i  (cfg_unit),
        .range_i (cfg_range),
        .cfg_o   (cfg_q),
        .blank_o (sts_block)
    );

    dbf_timer #(
        .TICKS_FINE   (TICKS_FINE),
        .TICKS_MID    (TICKS_MID),
        .TICKS_COARSE (TICKS_COARSE),
        .TICKS_MAX    (TICKS_MAX),
        .CNT_W        (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (rtc_tick),
        .clr    (cfg_we),
        .lvl    (sync_lvl),
        .cfg    (cfg_q),
        .out    (pin_filt),
        .cnt    (tmr_cnt),
        .target (tmr_target)
    );
endmodule

// File: rtl/dbf_chk.sv
module dbf_chk
    import dbf_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             tick,
    input logic             lvl,
    input logic             out,
    input logic             blank,
    input flt_mode_e        mode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] target
);
    // R10
    blank_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> blank);

    // R10
    blank_single_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> !blank);

    // R3
    out_from_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out) |-> out == $past(lvl));

    // R2
    off_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == FLT_OFF && !cfg_we) |=> out == $past(lvl));

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == FLT_BOTH && !tick) |=> $stable(out));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < target);
endmodule

bind glitch_filter dbf_chk #(.CNT_W(CNT_W)) u_dbf_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_we (cfg_we),
    .tick   (rtc_tick),
    .lvl    (sync_lvl),
    .out    (pin_filt),
    .blank  (sts_block),
    .mode   (cfg_q.mode),
    .cnt    (tmr_cnt),
    .target (tmr_target)
);

// File: tb/test_glitch_filter.sv
`timescale 1ns/1ps
module test_glitch_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rtc_tick = 1'b1;
    logic       pin_raw = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [3:0] cfg_count = 4'd0;
    logic       cfg_unit = 1'b0;
    logic       cfg_range = 1'b0;
    logic       pin_filt;
    logic       sts_block;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    glitch_filter i_glitch_filter (
        .clk       (clk),
        .rst       (rst),
        .rtc_tick  (rtc_tick),
        .pin_raw   (pin_raw),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .cfg_count (cfg_count),
        .cfg_unit  (cfg_unit),
        .cfg_range (cfg_range),
        .pin_filt  (pin_filt),
        .sts_block (sts_block)
    );

    // Row fields: mode[28:27] count[26:23] unit[22] range[21] rise[20] expected T[19:4] req[3:0]
    localparam logic [28:0] VEC [13] = '{
        {2'd0, 4'd5,  1'b1, 1'b1, 1'b1, 16'd1,     4'd2},  // R2 off, rise
        {2'd0, 4'd5,  1'b1, 1'b1, 1'b0, 16'd1,     4'd2},  // R2 off, fall
        {2'd1, 4'd3,  1'b0, 1'b0, 1'b1, 16'd6,     4'd3},  // R3 3 x 2
        {2'd1, 4'd3,  1'b0, 1'b0, 1'b0, 16'd6,     4'd3},  // R3 fall
        {2'd1, 4'd2,  1'b1, 1'b0, 1'b1, 16'd16,    4'd4},  // R4 2 x 8
        {2'd1, 4'd1,  1'b0, 1'b1, 1'b1, 16'd512,   4'd4},  // R4 1 x 512
        {2'd1, 4'd15, 1'b1, 1'b1, 1'b0, 16'd30720, 4'd4},  // R4 15 x 2048
        {2'd1, 4'd0,  1'b0, 1'b0, 1'b1, 16'd2,     4'd5},  // R5 zero -> one unit
        {2'd1, 4'd0,  1'b1, 1'b1, 1'b1, 16'd2048,  4'd5},  // R5 zero, largest unit
        {2'd2, 4'd4,  1'b0, 1'b0, 1'b0, 16'd1,     4'd7},  // R7 fall passes
        {2'd2, 4'd4,  1'b0, 1'b0, 1'b1, 16'd8,     4'd7},  // R7 rise filtered
        {2'd3, 4'd4,  1'b0, 1'b0, 1'b1, 16'd1,     4'd8},  // R8 rise passes
        {2'd3, 4'd4,  1'b0, 1'b0, 1'b0, 16'd8,     4'd8}   // R8 fall filtered
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] m, input logic [3:0] c, input logic u, input logic r);
        @(negedge clk);
        cfg_mode = m; cfg_count = c; cfg_unit = u; cfg_range = r; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle(input logic lvl);
        int n = 0;
        pin_raw = lvl;
        while (pin_filt !== lvl && n < 40000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    // Rising edges from a pin change (made at a falling edge) until pin_filt follows.
    task automatic measure(input logic lvl, output int n);
        n = 0;
        pin_raw = lvl;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (pin_filt !== lvl && n < 40000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pin_filt === 1'b0, "R1 pin_filt", pin_filt, 0);
        check(sts_block === 1'b0, "R1 sts_block", sts_block, 0);
        rst = 1'b0;

        // R10 write pulse: high one cycle after the write, then low
        @(negedge clk);
        cfg_mode = 2'd0; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        check(sts_block === 1'b1, "R10 pulse high", sts_block, 1);
        @(negedge clk);
        check(sts_block === 1'b0, "R10 pulse ends", sts_block, 0);

        // Table walk: exact latency 2+T (off and unfiltered edges: T=1)
        for (int i = 0; i < 13; i++) begin
            logic [28:0] v;
            int expl;
            v = VEC[i];
            cfg_write(v[28:27], v[26:23], v[22], v[21]);
            settle(~v[20]);
            measure(v[20], lat);
            expl = 2 + int'(v[19:4]);
            check(lat == expl, $sformatf("R%0d row %0d latency", v[3:0], i), lat, expl);
        end

        // R6 short high pulse (4 cycles) against T=6 in reject-both mode
        cfg_write(2'd1, 4'd3, 1'b0, 1'b0);
        settle(1'b0);
        pin_raw = 1'b1;
        repeat (4) @(negedge clk);
        pin_raw = 1'b0;
        begin
            logic seen = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (pin_filt !== 1'b0) seen = 1'b1;
            end
            check(!seen, "R6 glitch removed", seen, 0);
        end

        // R6 restart: high 4, low 1, high again -> latency 8 from the last rise
        pin_raw = 1'b1;
        repeat (4) @(negedge clk);
        pin_raw = 1'b0;
        @(negedge clk);
        measure(1'b1, lat);
        check(lat == 8, "R6 restart latency", lat, 8);

        // R7 keep-low mode removes a short high pulse (3 cycles, T=8)
        cfg_write(2'd2, 4'd4, 1'b0, 1'b0);
        settle(1'b0);
        pin_raw = 1'b1;
        repeat (3) @(negedge clk);
        pin_raw = 1'b0;
        begin
            logic seen = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (pin_filt !== 1'b0) seen = 1'b1;
            end
            check(!seen, "R7 high pulse removed", seen, 0);
        end

        // R8 keep-high mode removes a short low pulse
        cfg_write(2'd3, 4'd4, 1'b0, 1'b0);
        settle(1'b1);
        pin_raw = 1'b0;
        repeat (3) @(negedge clk);
        pin_raw = 1'b1;
        begin
            logic seen = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (pin_filt !== 1'b1) seen = 1'b1;
            end
            check(!seen, "R8 low pulse removed", seen, 0);
        end

        // R9 no ticks: transition held off, then completes two ticks later
        cfg_write(2'd1, 4'd1, 1'b0, 1'b0);
        settle(1'b0);
        rtc_tick = 1'b0;
        pin_raw = 1'b1;
        repeat (30) @(negedge clk);
        check(pin_filt === 1'b0, "R9 held without ticks", pin_filt, 0);
        rtc_tick = 1'b1;
        @(negedge clk);
        check(pin_filt === 1'b0, "R9 one tick not enough", pin_filt, 0);
        @(negedge clk);
        check(pin_filt === 1'b1, "R9 done after two ticks", pin_filt, 1);

        // R10 a write in mid-count discards accumulated time (T=6)
        cfg_write(2'd1, 4'd3, 1'b0, 1'b0);
        settle(1'b0);
        pin_raw = 1'b1;
        repeat (6) @(negedge clk);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        check(pin_filt === 1'b0, "R10 write restarts count", pin_filt, 0);
        repeat (3) @(negedge clk);
        check(pin_filt === 1'b1, "R10 completes after restart", pin_filt, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule